// File: doc/BRIEF.md
# Chained Busy-Line Host Port for a 1-Wire Slot Engine

This block sits between a parallel-port style host and a separate 1-Wire slot engine. The host chooses a command with two level inputs, a data/clock line and a reset-select line. It then pulls an active-low enable low to start the operation. The block hands the engine a start strobe, a slot kind and a speed flag. While the engine works, the block signals busy on two status outputs. When the engine reports done, those outputs return to the downstream status inputs. The host then pulls the data/clock line low to ask for the sampled bit.

The two status outputs are shared by three uses: busy, result and plain passthrough of the downstream status lines. Because of this, several devices can be chained on one port. The enable is forwarded downstream on a dedicated output. During a bus reset the block watches its downstream inputs for the staggered reset-busy pattern of a following device. If it does not see that pattern, it declares itself the last device in the chain. It also keeps a speed bit that the host flips with a command that never reaches the bus.

All host-side and downstream inputs pass through two-flop synchronizers. Edges are taken from the synchronized copies. The stagger time is counted in ticks of an external 1 µs strobe.

Top module: `ow_host_port`

## Requirements
- R1: While the enable input is high and the block is idle, statOut1/statOut2 equal chainIn1/chainIn2 combinationally, with no clock delay.
- R2: A falling edge of the synchronized enable captures the command. For every command except the toggle, it gives exactly one slotStart pulse, with slotKind set as follows: 0 = bit slot (data/clock=1, reset-select=1), 1 = write-0 (data/clock=0, reset-select=1), 2 = bus reset (data/clock=1, reset-select=0). slotFast carries the speed bit at that moment. Changes of the command lines after capture have no effect on the slot.
- R3: For a bit or write-0 slot, both status outputs are low from the start until slotDone.
- R4: For a bus reset, statOut1 is low and statOut2 is high for STAGGER_US tick periods. After that both are low until slotDone. A slotDone that arrives during the stagger ends the busy period at once.
- R5: After slotDone, the status outputs follow the downstream inputs again.
- R6: After slotDone, a falling edge on the data/clock line with a sampled bit of 0 drives both outputs low. They stay low until the enable rises, whatever the downstream inputs do. With a sampled bit of 1, the outputs keep following the downstream inputs.
- R7: When the synchronized enable goes high after an operation, the block returns to idle passthrough.
- R8: The speed bit is 0 after reset, and slotFast shows it. Data/clock=0 with reset-select=0 flips the speed bit and issues no slotStart. Until the enable rises, the outputs then follow the downstream inputs if the new bit is 1, or are both low if the new bit is 0.
- R9: A bus reset decides the chain position when it completes. If chainIn1=0 with chainIn2=1 was seen while busy, the block is not last; otherwise it is last. After reset the block is not last.
- R10: A block that is not last drives enOut equal to enIn. A block that is last holds enOut high, and while the enable is low it shows 1 on both status outputs in place of the downstream inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickUs | input | 1 | One-cycle strobe every microsecond |
| enIn | input | 1 | Active-low operation enable from host |
| cmdDataClk | input | 1 | Data/clock command line; falling edge asks for the result |
| cmdReset | input | 1 | Reset-select command line |
| chainIn1 | input | 1 | Downstream status input 1 |
| chainIn2 | input | 1 | Downstream status input 2 |
| statOut1 | output | 1 | Status/busy output 1 to host |
| statOut2 | output | 1 | Status/busy output 2 to host |
| enOut | output | 1 | Enable forwarded downstream |
| slotStart | output | 1 | One-cycle start strobe to slot engine |
| slotKind | output | 2 | Slot kind: 0 bit, 1 write-0, 2 reset |
| slotFast | output | 1 | Speed bit to slot engine |
| slotDone | input | 1 | Slot engine finished |
| slotBit | input | 1 | Sampled bus level, valid with slotDone |

## Verification
Two functions can collide on a bus reset: the engine's completion and the timed stagger of the reset-busy pattern. When they fall together, completion must win, the chain position must still be decided, and the stagger counter must not drive the block back into a busy state. The bench provokes this by raising slotDone a few cycles into the stagger, well before the second microsecond tick, while holding the downstream inputs high. It then judges the outcome at the ports. The outputs must leave the staggered pattern, the block must be marked last (enOut high, both outputs high even with downstream low), and no further busy level may appear before the enable rises.

// File: rtl/ow_host_pkg.sv
package ow_host_pkg;

  typedef enum logic [1:0] {
    KIND_BIT = 2'd0,
    KIND_WR0 = 2'd1,
    KIND_RST = 2'd2
  } slotKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAG,
    ST_BUSY,
    ST_WAIT,
    ST_LOWHOLD,
    ST_TOGGLE
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       takeBit;
    logic       watchChain;
    logic       decideLast;
    logic       forceEn;
    logic [1:0] forceVal;   // bit0 -> output 1, bit1 -> output 2
    logic       hideChain;
  } ctlStrobe_t;

endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // STAGES must be at least 2
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= {STAGES{RST_VAL}};
    else       stg <= {stg[STAGES-2:0], din};
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ow_host_ctl.sv
module ow_host_ctl
  import ow_host_pkg::*;
#(
  parameter int STAGGER_US = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickUs,
  input  logic       eniS,
  input  logic       cmdD,
  input  logic       cmdR,
  input  logic       slotDone,
  input  logic       bitSaved,
  input  logic       odMode,
  input  logic       capIsRst,
  output ctlStrobe_t strb,
  output logic       slotStart,
  output slotKind_e  slotKind
);
  localparam int CW = $clog2(STAGGER_US + 1);
  localparam logic [CW-1:0] STAG_LAST = CW'(STAGGER_US - 1);

  ctlState_e state, nxt;
  logic [CW-1:0] stagCnt;
  logic eniPrev, dclkPrev;
  logic eniFall, dclkFall, cmdToggle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eniPrev  <= 1'b1;
      dclkPrev <= 1'b1;
    end else begin
      eniPrev  <= eniS;
      dclkPrev <= cmdD;
    end
  end

  assign eniFall   = eniPrev & ~eniS;
  assign dclkFall  = dclkPrev & ~cmdD;
  assign cmdToggle = ~cmdD & ~cmdR;

  always_comb begin
    case ({cmdD, cmdR})
      2'b01:   slotKind = KIND_WR0;
      2'b10:   slotKind = KIND_RST;
      default: slotKind = KIND_BIT;
    endcase
  end

  always_comb begin
    nxt       = state;
    strb      = '0;
    slotStart = 1'b0;
    case (state)
      ST_IDLE: begin
        if (eniFall) begin
          strb.capture = 1'b1;
          if (cmdToggle) nxt = ST_TOGGLE;
          else begin
            slotStart = 1'b1;
            nxt = (slotKind == KIND_RST) ? ST_STAG : ST_BUSY;
          end
        end
      end
      ST_STAG: begin
        strb.forceEn    = 1'b1;
        strb.forceVal   = 2'b10;
        strb.watchChain = 1'b1;
        if (slotDone) begin
          strb.takeBit    = 1'b1;
          strb.decideLast = 1'b1;
          nxt = ST_WAIT;
        end else if (tickUs && stagCnt == STAG_LAST) begin
          nxt = ST_BUSY;
        end
      end
      ST_BUSY: begin
        strb.forceEn    = 1'b1;
        strb.forceVal   = 2'b00;
        strb.watchChain = capIsRst;
        if (slotDone) begin
          strb.takeBit    = 1'b1;
          strb.decideLast = capIsRst;
          nxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strb.hideChain = 1'b1;
        if (eniS) nxt = ST_IDLE;
        else if (dclkFall && !bitSaved) nxt = ST_LOWHOLD;
      end
      ST_LOWHOLD: begin
        strb.forceEn  = 1'b1;
        strb.forceVal = 2'b00;
        if (eniS) nxt = ST_IDLE;
      end
      ST_TOGGLE: begin
        if (odMode) strb.hideChain = 1'b1;
        else begin
          strb.forceEn  = 1'b1;
          strb.forceVal = 2'b00;
        end
        if (eniS) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stagCnt <= '0;
    end else begin
      state <= nxt;
      if (state != ST_STAG) stagCnt <= '0;
      else if (tickUs)      stagCnt <= stagCnt + 1'b1;
    end
  end

  p_start_leaves_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |=> (state == ST_STAG || state == ST_BUSY));

  p_busy_until_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !slotDone) |=> state == ST_BUSY);

  p_stagger_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STAG) |-> stagCnt < CW'(STAGGER_US));

  p_low_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOWHOLD && !eniS) |=> state == ST_LOWHOLD);
endmodule

// File: rtl/ow_host_dp.sv
module ow_host_dp
  import ow_host_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strb,
  input  logic       cmdD,
  input  logic       cmdR,
  input  logic       slotBit,
  input  logic [1:0] chainRaw,
  input  logic [1:0] chainSync,
  input  logic       enInRaw,
  output logic [1:0] statOut,
  output logic       enOut,
  output logic       bitSaved,
  output logic       odMode,
  output logic       lastDev,
  output logic       capIsRst
);
  logic capD, capR, seen, seenNow;

  assign seenNow  = strb.watchChain & ~chainSync[0] & chainSync[1];
  assign capIsRst = capD & ~capR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capD     <= 1'b1;
      capR     <= 1'b1;
      bitSaved <= 1'b1;
      odMode   <= 1'b0;
      seen     <= 1'b0;
      lastDev  <= 1'b0;
    end else begin
      if (strb.capture) begin
        capD <= cmdD;
        capR <= cmdR;
        if (!cmdD && !cmdR) odMode <= ~odMode;
      end
      if (strb.takeBit) bitSaved <= slotBit;
      if (strb.capture)  seen <= 1'b0;
      else if (seenNow)  seen <= 1'b1;
      if (strb.decideLast) lastDev <= ~(seen | seenNow);
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_chan
    always_comb begin
      if (strb.forceEn)                    statOut[c] = strb.forceVal[c];
      else if (strb.hideChain && lastDev)  statOut[c] = 1'b1;
      else                                 statOut[c] = chainRaw[c];
    end
  end

  assign enOut = lastDev | enInRaw;

  p_od_only_toggle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.capture && !cmdD && !cmdR) |=> $stable(odMode));

  p_last_only_on_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.decideLast |=> $stable(lastDev));
endmodule

// File: rtl/ow_host_port.sv
module ow_host_port
  import ow_host_pkg::*;
#(
  parameter int STAGGER_US  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickUs,
  input  logic       enIn,
  input  logic       cmdDataClk,
  input  logic       cmdReset,
  input  logic       chainIn1,
  input  logic       chainIn2,
  output logic       statOut1,
  output logic       statOut2,
  output logic       enOut,
  output logic       slotStart,
  output logic [1:0] slotKind,
  output logic       slotFast,
  input  logic       slotDone,
  input  logic       slotBit
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] syncOut;
  logic       eniS, cmdD, cmdR;
  logic [1:0] chainSync, statVec;
  logic       bitSaved, odMode, lastDev, capIsRst;
  ctlStrobe_t strb;
  slotKind_e  kindE;

  ow_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({chainIn2, chainIn1, cmdReset, cmdDataClk, enIn}),
    .dout(syncOut)
  );

  assign eniS      = syncOut[0];
  assign cmdD      = syncOut[1];
  assign cmdR      = syncOut[2];
  assign chainSync = syncOut[4:3];

  ow_host_ctl #(.STAGGER_US(STAGGER_US)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .tickUs   (tickUs),
    .eniS     (eniS),
    .cmdD     (cmdD),
    .cmdR     (cmdR),
    .slotDone (slotDone),
    .bitSaved (bitSaved),
    .odMode   (odMode),
    .capIsRst (capIsRst),
    .strb     (strb),
    .slotStart(slotStart),
    .slotKind (kindE)
  );

  ow_host_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdD     (cmdD),
    .cmdR     (cmdR),
    .slotBit  (slotBit),
    .chainRaw ({chainIn2, chainIn1}),
    .chainSync(chainSync),
    .enInRaw  (enIn),
    .statOut  (statVec),
    .enOut    (enOut),
    .bitSaved (bitSaved),
    .odMode   (odMode),
    .lastDev  (lastDev),
    .capIsRst (capIsRst)
  );

  assign statOut1 = statVec[0];
  assign statOut2 = statVec[1];
  assign slotKind = kindE;
  assign slotFast = odMode;
endmodule

// File: tb/ow_host_port_bench.sv
module ow_host_port_bench;
  logic clk = 1'b0;
  logic rstN, tickUs, enIn, cmdDataClk, cmdReset, chainIn1, chainIn2;
  logic slotDone, slotBit;
  logic statOut1, statOut2, enOut, slotStart, slotFast;
  logic [1:0] slotKind;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct packed { logic [1:0] kind; logic fast; } startItem_t;
  startItem_t expQ[$];

  always #5 clk = ~clk;

  ow_host_port u_ow_host_port (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .enIn(enIn),
    .cmdDataClk(cmdDataClk), .cmdReset(cmdReset),
    .chainIn1(chainIn1), .chainIn2(chainIn2),
    .statOut1(statOut1), .statOut2(statOut2), .enOut(enOut),
    .slotStart(slotStart), .slotKind(slotKind), .slotFast(slotFast),
    .slotDone(slotDone), .slotBit(slotBit)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every start strobe must match a queued expectation
  always @(negedge clk) begin
    if (rstN && slotStart) begin
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R2 actual=start expected=none");
      end else begin
        startItem_t e;
        e = expQ.pop_front();
        if ({slotKind, slotFast} !== {e.kind, e.fast}) begin
          fails++;
          $display("FAIL R2 actual=%0h expected=%0h", {slotKind, slotFast}, {e.kind, e.fast});
        end
      end
    end
  end

  initial begin
    tickUs = 1'b0;
    forever begin
      repeat (19) @(negedge clk);
      tickUs = 1'b1;
      @(negedge clk);
      tickUs = 1'b0;
    end
  end

  task automatic startOp(input logic d, input logic r, input bit pushIt,
                         input logic [1:0] kind, input logic fast);
    cmdDataClk = d;
    cmdReset   = r;
    cycles(3);
    if (pushIt) expQ.push_back('{kind: kind, fast: fast});
    enIn = 1'b0;
    cycles(4);
  endtask

  task automatic engineDone(input logic b);
    slotDone = 1'b1;
    slotBit  = b;
    cycles(1);
    slotDone = 1'b0;
    cycles(3);
  endtask

  task automatic query();
    cmdDataClk = 1'b1;
    cycles(4);
    cmdDataClk = 1'b0;
    cycles(4);
  endtask

  task automatic endOp();
    enIn = 1'b1;
    cycles(4);
  endtask

  initial begin
    rstN = 1'b0; enIn = 1'b1; cmdDataClk = 1'b1; cmdReset = 1'b1;
    chainIn1 = 1'b1; chainIn2 = 1'b0; slotDone = 1'b0; slotBit = 1'b1;
    cycles(3);
    rstN = 1'b1;
    cycles(2);
    // reset state and passthrough
    chk("R1 reset passthrough", {statOut2, statOut1}, 4'b01);
    chk("R8 speed bit after reset", slotFast, 1'b0);
    chk("R10 enOut follows high enable", enOut, 1'b1);
    chainIn1 = 1'b0; chainIn2 = 1'b1; #1;
    chk("R1 combinational passthrough", {statOut2, statOut1}, 4'b10);
    cycles(1);

    // bit slot, result 1
    chainIn1 = 1'b1; chainIn2 = 1'b1;
    startOp(1'b1, 1'b1, 1'b1, 2'd0, 1'b0);
    chk("R3 bit slot busy", {statOut2, statOut1}, 4'b00);
    chk("R10 enOut tracks low enable", enOut, 1'b0);
    cmdDataClk = 1'b0; cmdReset = 1'b0;     // late change, must be ignored
    cycles(6);
    chk("R2 late command change ignored", {statOut2, statOut1}, 4'b00);
    chk("R8 late toggle code does not flip speed", slotFast, 1'b0);
    cmdReset = 1'b1;
    engineDone(1'b1);
    chk("R5 done restores chain", {statOut2, statOut1}, 4'b11);
    query();
    chainIn1 = 1'b1; chainIn2 = 1'b0; cycles(1);
    chk("R6 result 1 keeps following", {statOut2, statOut1}, 4'b01);
    endOp();
    chk("R7 idle after enable rise", {statOut2, statOut1}, 4'b01);

    // write-0 slot, result 0
    chainIn1 = 1'b1; chainIn2 = 1'b1;
    startOp(1'b0, 1'b1, 1'b1, 2'd1, 1'b0);
    chk("R3 write0 busy", {statOut2, statOut1}, 4'b00);
    engineDone(1'b0);
    chk("R5 follow before query", {statOut2, statOut1}, 4'b11);
    query();
    chk("R6 result 0 low", {statOut2, statOut1}, 4'b00);
    chainIn1 = 1'b1; chainIn2 = 1'b0; cycles(3);
    chk("R6 low held despite chain", {statOut2, statOut1}, 4'b00);
    endOp();
    chk("R7 passthrough after low hold", {statOut2, statOut1}, 4'b01);

    // bus reset with downstream pattern present
    chainIn1 = 1'b1; chainIn2 = 1'b1;
    startOp(1'b1, 1'b0, 1'b1, 2'd2, 1'b0);
    chk("R4 stagger pattern", {statOut2, statOut1}, 4'b10);
    chainIn1 = 1'b0; chainIn2 = 1'b1; cycles(10);
    chainIn1 = 1'b0; chainIn2 = 1'b0; cycles(50);
    chk("R4 both low after stagger", {statOut2, statOut1}, 4'b00);
    chainIn1 = 1'b1; chainIn2 = 1'b1;
    engineDone(1'b0);
    chk("R5 reset done follows", {statOut2, statOut1}, 4'b11);
    chk("R9 pattern seen, not last", enOut, 1'b0);
    query();
    chk("R6 presence reads low", {statOut2, statOut1}, 4'b00);
    endOp();

    // speed toggle on
    startOp(1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    chainIn1 = 1'b0; chainIn2 = 1'b1; cycles(1);
    chk("R8 toggle to fast shows chain", {statOut2, statOut1}, 4'b10);
    chk("R8 speed bit set", slotFast, 1'b1);
    endOp();
    chainIn1 = 1'b1; chainIn2 = 1'b1;
    startOp(1'b1, 1'b1, 1'b1, 2'd0, 1'b1);
    engineDone(1'b1);
    endOp();
    // speed toggle off
    startOp(1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R8 toggle to normal drives low", {statOut2, statOut1}, 4'b00);
    chk("R8 speed bit cleared", slotFast, 1'b0);
    endOp();

    // reset without downstream pattern, early done during stagger
    chainIn1 = 1'b1; chainIn2 = 1'b1;
    startOp(1'b1, 1'b0, 1'b1, 2'd2, 1'b0);
    chk("R4 stagger before early done", {statOut2, statOut1}, 4'b10);
    engineDone(1'b1);
    chainIn1 = 1'b0; chainIn2 = 1'b0; cycles(30);
    chk("R10 last hides chain", {statOut2, statOut1}, 4'b11);
    chk("R9 no pattern, last", enOut, 1'b1);
    endOp();
    chk("R1 last still passes when idle", {statOut2, statOut1}, 4'b00);
    chk("R10 last holds enOut high", enOut, 1'b1);

    // reset with pattern again -> not last
    chainIn1 = 1'b1; chainIn2 = 1'b1;
    startOp(1'b1, 1'b0, 1'b1, 2'd2, 1'b0);
    chainIn1 = 1'b0; chainIn2 = 1'b1; cycles(8);
    chainIn1 = 1'b1; chainIn2 = 1'b1;
    engineDone(1'b1);
    chk("R9 pattern clears last", enOut, 1'b0);
    endOp();
    chk("R2 all starts consumed", expQ.size(), 4'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule